// File: doc/BRIEF.md
# PLL Lock Status Aggregator

The block merges the lock flags of one transmit PLL and a set of receive PLLs (two by default) into one filtered lock status. The raw flags come from other clock domains, so each passes through a synchronizer before it is used. Lock is declared only after every flag has stayed high for a long qualification window. Lock is withdrawn only after some flag has stayed low for a second, longer window. Any loss of lock is followed by a minimum time in the unlocked state.

An external active-low reset request, qualified by a minimum pulse width, also forces the status to unlocked. The output is a pull-down enable for an open-drain line, so several instances can share one combined lock wire. All windows are counted in reference-clock cycles and set by parameters: at 125 MHz the defaults are 49,250 cycles to lock, 131,625 cycles to unlock and 49,250 cycles of minimum unlocked time.

Top module: `lock_status_agg`

## Requirements
- R1: While `rst` is high at a clock edge, `lock_pull_low` is 1 (line pulled low, unlocked) after that edge.
- R2: With the minimum unlocked time already served, `lock_pull_low` falls to 0 exactly ASSERT_CYC+2 clock edges after all raw lock flags go high together, and is still 1 one edge earlier (two edges are synchronizer latency).
- R3: A low on any lock flag during lock qualification, even for one cycle, restarts the lock window, which then runs from the edge on which all flags are high again.
- R4: From the locked state (`lock_pull_low`=0), `lock_pull_low` rises to 1 exactly DEASSERT_CYC+2 edges after any raw flag goes low and stays low, and not one edge earlier.
- R5: All flags returning high for a single cycle during unlock qualification restarts the unlock window.
- R6: Once `lock_pull_low` becomes 1 for any reason, it stays 1 for at least HOLD_CYC clock edges.
- R7: `ext_rst_n` held low for RST_MIN_LOW or more consecutive sampled cycles sets `lock_pull_low` to 1 on edge RST_MIN_LOW+2 after the first low sample. The minimum unlocked time restarts from the last edge of that qualified low.
- R8: An `ext_rst_n` low pulse shorter than RST_MIN_LOW cycles does not change `lock_pull_low`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_rst_n | input | 1 | External reset request, active low, asynchronous |
| tx_lock_raw | input | 1 | Raw transmit PLL lock flag, asynchronous |
| rx_lock_raw | input | NUM_RX | Raw receive PLL lock flags, asynchronous |
| lock_pull_low | output | 1 | 1 pulls the shared lock line low (unlocked); 0 releases it (locked) |

## Verification
On every cycle, the assertions check four things. Release happens only on an edge where the synchronized flags were all high. A rise needs a synchronized low flag or a qualified external reset. The output never releases before the minimum unlocked time has passed. A qualified external reset always pulls the line on the next edge. The exact window lengths cannot be seen by these checks and only the bench scenarios show them: lock at N edges but not at N-1, restart after single-cycle glitches in either direction, rejection of short reset pulses, and the hold time winning over the lock window. The bench's behavioural model also compares the output on every clock.

// File: rtl/lock_agg_pkg.sv
package lock_agg_pkg;

  typedef enum logic {
    LINE_RELEASE = 1'b0,
    LINE_PULL    = 1'b1
  } line_e;

  function automatic int unsigned cnt_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/lock_flag_sync.sv
module lock_flag_sync #(
  parameter int unsigned W       = 1,
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < int'(STAGES); i++) stg[i] <= {W{RST_VAL}};
    end else begin
      stg[0] <= d;
      for (int i = 1; i < int'(STAGES); i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/run_qualifier.sv
module run_qualifier #(
  parameter int unsigned LEN = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic restart,
  output logic met
);

  localparam int unsigned CW   = lock_agg_pkg::cnt_width(LEN);
  localparam logic [CW-1:0] LAST = CW'(LEN - 1);

  logic [CW-1:0] cnt;

  // cnt holds how many edges in a row 'run' was already true, saturating
  always_ff @(posedge clk) begin
    if (rst || restart || !run) cnt <= '0;
    else if (cnt != LAST)       cnt <= cnt + CW'(1);
  end

  // true on the edge that completes LEN consecutive run cycles (or later)
  assign met = run && (cnt == LAST);

endmodule

// File: rtl/lock_status_agg.sv
module lock_status_agg #(
  parameter int unsigned NUM_RX       = 2,
  parameter int unsigned SYNC_STAGES  = 2,
  parameter int unsigned ASSERT_CYC   = 49250,
  parameter int unsigned DEASSERT_CYC = 131625,
  parameter int unsigned HOLD_CYC     = 49250,
  parameter int unsigned RST_MIN_LOW  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ext_rst_n,
  input  logic              tx_lock_raw,
  input  logic [NUM_RX-1:0] rx_lock_raw,
  output logic              lock_pull_low
);
  import lock_agg_pkg::*;

  localparam int unsigned NF = NUM_RX + 1;

  logic [NF-1:0] flags_s;
  logic          ext_s;
  logic          all_hi;
  logic          hi_met, lo_met, ext_hit, hold_met;
  logic          go_low, release_ok;
  line_e         line_q;
  logic          pulled;

  lock_flag_sync #(.W(NF), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_flag_sync (
    .clk (clk),
    .rst (rst),
    .d   ({rx_lock_raw, tx_lock_raw}),
    .q   (flags_s)
  );

  lock_flag_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_ext_sync (
    .clk (clk),
    .rst (rst),
    .d   (ext_rst_n),
    .q   (ext_s)
  );

  assign all_hi = &flags_s;
  assign pulled = (line_q == LINE_PULL);

  run_qualifier #(.LEN(ASSERT_CYC)) u_hi_win (
    .clk (clk), .rst (rst), .run (all_hi), .restart (1'b0), .met (hi_met)
  );

  run_qualifier #(.LEN(DEASSERT_CYC)) u_lo_win (
    .clk (clk), .rst (rst), .run (!all_hi), .restart (1'b0), .met (lo_met)
  );

  run_qualifier #(.LEN(RST_MIN_LOW)) u_ext_win (
    .clk (clk), .rst (rst), .run (!ext_s), .restart (1'b0), .met (ext_hit)
  );

  // minimum unlocked time, restarted on every edge that pulls the line
  run_qualifier #(.LEN(HOLD_CYC)) u_hold_win (
    .clk (clk), .rst (rst), .run (pulled), .restart (go_low), .met (hold_met)
  );

  assign go_low     = ext_hit || (!pulled && lo_met);
  assign release_ok = pulled && !ext_hit && hold_met && hi_met;

  always_ff @(posedge clk) begin
    if (rst)             line_q <= LINE_PULL;
    else if (go_low)     line_q <= LINE_PULL;
    else if (release_ok) line_q <= LINE_RELEASE;
  end

  assign lock_pull_low = pulled;

endmodule

// File: rtl/lock_status_agg_chk.sv
module lock_status_agg_chk #(
  parameter int unsigned HOLD_CYC = 4
) (
  input logic clk,
  input logic rst,
  input logic pull_low,
  input logic all_hi,
  input logic ext_hit
);

  logic rst_q = 1'b0;
  int unsigned age;

  always_ff @(posedge clk) begin
    rst_q <= rst;
    if (rst || !pull_low)    age <= 0;
    else if (age < HOLD_CYC) age <= age + 1;
  end

  always_ff @(posedge clk) begin
    if (rst_q) begin
      AST_RESET_PULLS: assert (pull_low); // R1
    end
  end

  AST_RELEASE_NEEDS_ALL_HI: assert property (@(posedge clk) disable iff (rst)
    $fell(pull_low) |-> $past(all_hi)); // R2

  AST_PULL_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $rose(pull_low) |-> ($past(!all_hi) || $past(ext_hit) || $past(rst))); // R4

  AST_MIN_HOLD: assert property (@(posedge clk) disable iff (rst)
    $fell(pull_low) |-> ($past(age) >= HOLD_CYC - 1)); // R6

  AST_EXT_FORCES_PULL: assert property (@(posedge clk) disable iff (rst)
    ext_hit |=> pull_low); // R7

endmodule

bind lock_status_agg lock_status_agg_chk #(.HOLD_CYC(HOLD_CYC)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .pull_low (lock_pull_low),
  .all_hi   (all_hi),
  .ext_hit  (ext_hit)
);

// File: tb/lock_status_agg_tb_top.sv
module lock_status_agg_tb_top;

  localparam int A = 16;
  localparam int D = 24;
  localparam int H = 30;
  localparam int R = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ext_n = 1'b1;
  logic       tx_raw = 1'b0;
  logic [1:0] rx_raw = 2'b00;
  logic       pull;

  int checks = 0;
  int fails  = 0;
  bit started = 1'b0;

  always #10 clk = ~clk;

  lock_status_agg #(
    .NUM_RX(2), .SYNC_STAGES(2), .ASSERT_CYC(A), .DEASSERT_CYC(D),
    .HOLD_CYC(H), .RST_MIN_LOW(R)
  ) dut_i (
    .clk (clk), .rst (rst), .ext_rst_n (ext_n),
    .tx_lock_raw (tx_raw), .rx_lock_raw (rx_raw), .lock_pull_low (pull)
  );

  // behavioural reference: delay lines plus run lengths in integers
  logic [2:0] m_s1, m_s2;
  logic       m_e1, m_e2;
  int hi_run, lo_run, rl_run, low_age;
  logic m_exp = 1'b1;

  always @(posedge clk) begin
    if (rst) begin
      m_s1 = '0; m_s2 = '0; m_e1 = 1'b1; m_e2 = 1'b1;
      hi_run = 0; lo_run = 0; rl_run = 0; low_age = 0; m_exp = 1'b1;
    end else begin
      hi_run = (&m_s2)  ? hi_run + 1 : 0;
      lo_run = (&m_s2)  ? 0 : lo_run + 1;
      rl_run = (!m_e2)  ? rl_run + 1 : 0;
      if (rl_run >= R) begin
        m_exp = 1'b1; low_age = 0;
      end else if (m_exp) begin
        if (low_age >= H - 1 && hi_run >= A) m_exp = 1'b0;
        else low_age = low_age + 1;
      end else if (lo_run >= D) begin
        m_exp = 1'b1; low_age = 0;
      end
      m_s2 = m_s1; m_s1 = {rx_raw, tx_raw};
      m_e2 = m_e1; m_e1 = ext_n;
    end
    started = 1'b1;
  end

  task automatic chk(input bit ok, input string req, input logic act, input logic expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: lock_pull_low=%0b expected %0b at %0t", req, act, expv, $time);
    end
  endtask

  // model comparison on every cycle, away from the edge
  always @(negedge clk) begin
    if (started) chk(pull === m_exp, "model", pull, m_exp);
  end

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic expect_pull(input logic v, input string req);
    chk(pull === v, req, pull, v);
  endtask

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog: lock_pull_low=%0b expected run end", pull);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    edges(3);
    expect_pull(1'b1, "R1 reset state");
    rst = 1'b0;
    edges(40);
    expect_pull(1'b1, "R6 no lock with flags low");

    // R2: lock at exactly A+2 edges, not at A+1
    tx_raw = 1'b1; rx_raw = 2'b11;
    edges(A + 1);
    expect_pull(1'b1, "R2 one edge early");
    edges(1);
    expect_pull(1'b0, "R2 exact lock edge");

    // R4: unlock at exactly D+2 edges
    rx_raw[1] = 1'b0;
    edges(D + 1);
    expect_pull(1'b0, "R4 one edge early");
    edges(1);
    expect_pull(1'b1, "R4 exact unlock edge");

    // R6: flags back at once, hold time dominates the lock window
    rx_raw[1] = 1'b1;
    edges(H - 1);
    expect_pull(1'b1, "R6 hold one edge early");
    edges(1);
    expect_pull(1'b0, "R6 release at hold end");

    // R3: unlock, serve the hold, then glitch during qualification
    tx_raw = 1'b0;
    edges(D + 2);
    expect_pull(1'b1, "R4 unlock before R3 scenario");
    edges(40);
    tx_raw = 1'b1;
    edges(10);
    rx_raw[0] = 1'b0;
    edges(1);
    rx_raw[0] = 1'b1;
    edges(A + 1);
    expect_pull(1'b1, "R3 window restarted by glitch");
    edges(1);
    expect_pull(1'b0, "R3 lock after restarted window");

    // R5: one-cycle recovery restarts the unlock window
    rx_raw[0] = 1'b0;
    edges(15);
    rx_raw[0] = 1'b1;
    edges(1);
    rx_raw[0] = 1'b0;
    edges(D + 1);
    expect_pull(1'b0, "R5 unlock window restarted");
    edges(1);
    expect_pull(1'b1, "R5 unlock after restarted window");
    rx_raw[0] = 1'b1;
    edges(H + 5);
    expect_pull(1'b0, "R6 relock after hold");

    // R8: short external reset pulse ignored
    ext_n = 1'b0;
    edges(R - 1);
    ext_n = 1'b1;
    edges(10);
    expect_pull(1'b0, "R8 short ext reset ignored");

    // R7: qualified external reset pulls the line and restarts the hold
    ext_n = 1'b0;
    edges(R);
    ext_n = 1'b1;
    edges(1);
    expect_pull(1'b0, "R7 one edge before ext qualification");
    edges(1);
    expect_pull(1'b1, "R7 ext reset pulls line");
    edges(H - 1);
    expect_pull(1'b1, "R7 hold after ext reset");
    edges(1);
    expect_pull(1'b0, "R7 release after ext hold");

    edges(5);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule